// File: doc/BRIEF.md
# Nibble-Prefix Operand Decoder

This block turns a stream of byte-wide stack-machine instructions into decoded operations. Each byte carries a function code in its upper nibble and a data nibble in its lower nibble. Prefix bytes grow a wide operand in a persistent operand register, four bits per prefix, before the instruction that uses it. A positive prefix extends the value as it is. A negative prefix complements it, so negative constants can be built.

Bytes enter through a valid/ready handshake at up to one byte per clock. Every non-prefix byte issues one registered output word. The word holds the function code, the full operand, the number of prefixes folded into it, and a flag. The flag marks an operate byte, whose operand selects a secondary operation instead of feeding a direct function. The block drives no datapath and only produces this decoded stream.

Top module: `nib_prefix_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the operand register and prefix count are zero. A first plain byte therefore issues with operand equal to its data nibble and a count of 0.
- R2: A byte splits into function code `in_byte[7:4]` and data nibble `in_byte[3:0]`. A non-prefix byte issues with `out_func` equal to its function code and operand equal to (operand register OR data nibble).
- R3: A byte with function code 0x2 is a positive prefix. It sets the operand register to (register OR nibble) shifted left by four, and it issues no output.
- R4: A byte with function code 0x6 is a negative prefix. It sets the operand register to the bitwise complement of (register OR nibble), shifted left by four, and it issues no output.
- R5: Issuing an instruction clears the operand register and the prefix count, so the next instruction starts from zero.
- R6: `out_secondary` is 1 exactly when the issued function code is 0xF (operate). In that case the operand names the secondary operation.
- R7: `out_npfx` reports how many prefix bytes were accepted since the previous issue, saturating at 2^PCNT_W-1.
- R8: `in_ready` is 1 whenever the output slot is empty or being taken. With `out_ready` held high, one byte is accepted every clock.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, the output word holds stable, and partial operand state is kept.
- R10: A non-prefix byte accepted at a clock edge shows as `out_valid` = 1 with its word right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| in_byte | input | 8 | Instruction byte (code in [7:4], data in [3:0]) |
| out_valid | output | 1 | Decoded word available |
| out_ready | input | 1 | Consumer takes the decoded word |
| out_secondary | output | 1 | Operand selects a secondary operation |
| out_func | output | 4 | Function code of the issuing byte |
| out_operand | output | OPND_W | Accumulated operand |
| out_npfx | output | PCNT_W | Prefix bytes folded into this operand |

## Verification
The hardest case to reach is a long, mixed prefix chain that is interrupted by output backpressure. There the partial operand must survive stalled cycles while a finished word is still waiting in the output slot. The stimulus draws prefix-heavy random bytes and pulls `out_ready` low at random. Directed runs add a chain longer than the count can hold, a negative prefix that produces all ones, and a held stall in the middle of a chain.

// File: rtl/npd_pkg.sv
package npd_pkg;

    localparam int NIB_W = 4;
    localparam int BYTE_W = 2 * NIB_W;

    localparam logic [NIB_W-1:0] FC_PFX_POS = 4'h2;
    localparam logic [NIB_W-1:0] FC_PFX_NEG = 4'h6;
    localparam logic [NIB_W-1:0] FC_OPERATE = 4'hF;

    typedef enum logic [1:0] {
        K_DIRECT  = 2'd0,
        K_PFX_POS = 2'd1,
        K_PFX_NEG = 2'd2,
        K_OPERATE = 2'd3
    } byte_kind_e;

    typedef struct packed {
        logic [NIB_W-1:0] code;
        logic [NIB_W-1:0] data;
    } ibyte_t;

    function automatic byte_kind_e kind_of(input logic [NIB_W-1:0] code);
        case (code)
            FC_PFX_POS: kind_of = K_PFX_POS;
            FC_PFX_NEG: kind_of = K_PFX_NEG;
            FC_OPERATE: kind_of = K_OPERATE;
            default:    kind_of = K_DIRECT;
        endcase
    endfunction

    function automatic logic is_prefix(input byte_kind_e k);
        is_prefix = (k == K_PFX_POS) || (k == K_PFX_NEG);
    endfunction

endpackage

// File: rtl/npd_classify.sv
module npd_classify
    import npd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output byte_kind_e        kind_o,
    output logic [NIB_W-1:0]  code_o,
    output logic [NIB_W-1:0]  data_o,
    output logic              prefix_o
);
    ibyte_t fields;

    always_comb begin
        fields   = ibyte_t'(byte_i);
        code_o   = fields.code;
        data_o   = fields.data;
        kind_o   = kind_of(fields.code);
        prefix_o = is_prefix(kind_of(fields.code));
    end
endmodule

// File: rtl/npd_opacc.sv
module npd_opacc
    import npd_pkg::*;
#(
    parameter int OPND_W = 32,
    parameter int PCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  byte_kind_e        kind_i,
    input  logic [NIB_W-1:0]  data_i,
    output logic [OPND_W-1:0] issue_opnd_o,
    output logic [PCNT_W-1:0] issue_cnt_o
);
    localparam logic [PCNT_W-1:0] CNT_MAX = {PCNT_W{1'b1}};

    logic [OPND_W-1:0] oreg_q;
    logic [PCNT_W-1:0] cnt_q;
    logic [OPND_W-1:0] merged;
    logic [OPND_W-1:0] pfx_next;

    always_comb begin
        merged = oreg_q | {{(OPND_W-NIB_W){1'b0}}, data_i};
        if (kind_i == K_PFX_NEG)
            pfx_next = (~merged) << NIB_W;
        else
            pfx_next = merged << NIB_W;
        issue_opnd_o = merged;
        issue_cnt_o  = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oreg_q <= '0;
            cnt_q  <= '0;
        end else if (step_i) begin
            if (is_prefix(kind_i)) begin
                oreg_q <= pfx_next;
                if (cnt_q != CNT_MAX)
                    cnt_q <= cnt_q + 1'b1;
            end else begin
                oreg_q <= '0;
                cnt_q  <= '0;
            end
        end
    end

    AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (step_i && !is_prefix(kind_i)) |=> (oreg_q == '0 && cnt_q == '0)); // R5

    AST_PFX_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (step_i && is_prefix(kind_i)) |=> (oreg_q[NIB_W-1:0] == '0)); // R3

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (step_i && is_prefix(kind_i) && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R7

endmodule

// File: rtl/npd_issue.sv
module npd_issue
    import npd_pkg::*;
#(
    parameter int OPND_W = 32,
    parameter int PCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              sec_i,
    input  logic [NIB_W-1:0]  code_i,
    input  logic [OPND_W-1:0] opnd_i,
    input  logic [PCNT_W-1:0] cnt_i,
    input  logic              out_ready_i,
    output logic              slot_free_o,
    output logic              out_valid_o,
    output logic              out_sec_o,
    output logic [NIB_W-1:0]  out_code_o,
    output logic [OPND_W-1:0] out_opnd_o,
    output logic [PCNT_W-1:0] out_cnt_o
);
    assign slot_free_o = !out_valid_o || out_ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            out_sec_o   <= 1'b0;
            out_code_o  <= '0;
            out_opnd_o  <= '0;
            out_cnt_o   <= '0;
        end else begin
            if (load_i) begin
                out_valid_o <= 1'b1;
                out_sec_o   <= sec_i;
                out_code_o  <= code_i;
                out_opnd_o  <= opnd_i;
                out_cnt_o   <= cnt_i;
            end else if (out_ready_i) begin
                out_valid_o <= 1'b0;
            end
        end
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_opnd_o)
            && $stable(out_code_o) && $stable(out_cnt_o) && $stable(out_sec_o))); // R9

    AST_SEC_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (out_sec_o == (out_code_o == FC_OPERATE))); // R6

endmodule

// File: rtl/nib_prefix_decoder.sv
module nib_prefix_decoder
    import npd_pkg::*;
#(
    parameter int OPND_W = 32,
    parameter int PCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_secondary,
    output logic [3:0]        out_func,
    output logic [OPND_W-1:0] out_operand,
    output logic [PCNT_W-1:0] out_npfx
);
    byte_kind_e        kind;
    logic [NIB_W-1:0]  code;
    logic [NIB_W-1:0]  data;
    logic              prefix;
    logic              accept;
    logic              issue;
    logic              slot_free;
    logic [OPND_W-1:0] issue_opnd;
    logic [PCNT_W-1:0] issue_cnt;

    npd_classify u_cls (
        .byte_i   (in_byte),
        .kind_o   (kind),
        .code_o   (code),
        .data_o   (data),
        .prefix_o (prefix)
    );

    assign in_ready = slot_free;
    assign accept   = in_valid && slot_free;
    assign issue    = accept && !prefix;

    npd_opacc #(.OPND_W(OPND_W), .PCNT_W(PCNT_W)) u_acc (
        .clk          (clk),
        .rst          (rst),
        .step_i       (accept),
        .kind_i       (kind),
        .data_i       (data),
        .issue_opnd_o (issue_opnd),
        .issue_cnt_o  (issue_cnt)
    );

    npd_issue #(.OPND_W(OPND_W), .PCNT_W(PCNT_W)) u_iss (
        .clk         (clk),
        .rst         (rst),
        .load_i      (issue),
        .sec_i       (kind == K_OPERATE),
        .code_i      (code),
        .opnd_i      (issue_opnd),
        .cnt_i       (issue_cnt),
        .out_ready_i (out_ready),
        .slot_free_o (slot_free),
        .out_valid_o (out_valid),
        .out_sec_o   (out_secondary),
        .out_code_o  (out_func),
        .out_opnd_o  (out_operand),
        .out_cnt_o   (out_npfx)
    );

    AST_PFX_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && prefix && (!out_valid || out_ready)) |=> !out_valid); // R3

    AST_ISSUE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !prefix) |=> out_valid); // R10

endmodule

// File: tb/sim_nib_prefix_decoder.sv
module sim_nib_prefix_decoder;
    localparam int OPND_W = 32;
    localparam int PCNT_W = 4;
    localparam int EW = 1 + 4 + OPND_W + PCNT_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_byte = 8'h00;
    logic out_valid;
    logic out_ready = 1'b0;
    logic out_secondary;
    logic [3:0] out_func;
    logic [OPND_W-1:0] out_operand;
    logic [PCNT_W-1:0] out_npfx;

    always #5 clk = ~clk;

    nib_prefix_decoder #(.OPND_W(OPND_W), .PCNT_W(PCNT_W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
        .out_secondary(out_secondary), .out_func(out_func),
        .out_operand(out_operand), .out_npfx(out_npfx)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [OPND_W-1:0] m_oreg = '0;
    logic [PCNT_W-1:0] m_cnt = '0;
    logic [EW-1:0] expq[$];

    logic hold_chk = 0;
    logic [EW-1:0] held;
    logic want_valid = 0;

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic bit is_pfx(input logic [7:0] b);
        return (b[7:4] == 4'h2) || (b[7:4] == 4'h6);
    endfunction

    function automatic logic [EW-1:0] out_word();
        return {out_secondary, out_func, out_operand, out_npfx};
    endfunction

    task automatic model(input logic [7:0] b);
        logic [OPND_W-1:0] m;
        m = m_oreg | {{(OPND_W-4){1'b0}}, b[3:0]};
        if (is_pfx(b)) begin
            m_oreg = (b[7:4] == 4'h6) ? ((~m) << 4) : (m << 4);
            if (m_cnt != {PCNT_W{1'b1}}) m_cnt = m_cnt + 1'b1;
        end else begin
            expq.push_back({(b[7:4] == 4'hF), b[7:4], m, m_cnt});
            m_oreg = '0;
            m_cnt = '0;
        end
    endtask

    task automatic step(input logic v, input logic [7:0] b, input logic ordy);
        logic [EW-1:0] e;
        bit infire;
        @(negedge clk);
        in_valid = v; in_byte = b; out_ready = ordy;
        #1;
        if (hold_chk)
            chk(out_valid === 1'b1 && out_word() === held, "R9 stalled word held",
                64'(out_word()), 64'(held));
        if (want_valid)
            chk(out_valid === 1'b1, "R10 valid after issue", 64'(out_valid), 64'd1);
        if (out_valid && ordy) begin
            if (expq.size() == 0) begin
                chk(0, "R3 R4 unexpected output", 64'(out_word()), 64'd0);
            end else begin
                e = expq.pop_front();
                chk(out_func === e[EW-2 -: 4], "R2 function code", 64'(out_func), 64'(e[EW-2 -: 4]));
                chk(out_operand === e[PCNT_W +: OPND_W], "R3 R4 R5 operand",
                    64'(out_operand), 64'(e[PCNT_W +: OPND_W]));
                chk(out_secondary === e[EW-1], "R6 secondary flag", 64'(out_secondary), 64'(e[EW-1]));
                chk(out_npfx === e[PCNT_W-1:0], "R7 prefix count", 64'(out_npfx), 64'(e[PCNT_W-1:0]));
            end
        end
        if (out_valid && !ordy) begin
            chk(in_ready === 1'b0, "R9 in_ready low in stall", 64'(in_ready), 64'd0);
            hold_chk = 1; held = out_word();
        end else begin
            hold_chk = 0;
        end
        infire = v && in_ready;
        if (infire) model(b);
        want_valid = infire && !is_pfx(b);
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(out_valid === 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        chk(in_ready === 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);

        // R1 R2: first plain byte after reset
        step(1, 8'h45, 1);
        // R3: positive chain 0x123
        step(1, 8'h21, 1); step(1, 8'h22, 1); step(1, 8'h43, 1);
        // R5: next instruction independent
        step(1, 8'h17, 1);
        // R4: negative prefix gives all ones
        step(1, 8'h60, 1); step(1, 8'h4F, 1);
        // R6: operate with prefix selects 0x10
        step(1, 8'h21, 1); step(1, 8'hF0, 1);
        // R7: count saturation
        for (int i = 0; i < 18; i++) step(1, 8'h20 | 8'(i % 16), 1);
        step(1, 8'h33, 1);
        // R9: stall in the middle of a chain
        step(1, 8'h71, 0); step(1, 8'h25, 0); step(1, 8'h26, 0);
        step(0, 8'h00, 0); step(1, 8'h25, 1); step(1, 8'h6A, 1); step(1, 8'hF3, 1);
        // R8: full throughput with plain bytes
        for (int i = 0; i < 20; i++) begin
            step(1, 8'h80 | 8'(i % 16), 1);
            chk(in_ready === 1'b1, "R8 one byte per clock", 64'(in_ready), 64'd1);
        end
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [7:0] b;
            r = int'($urandom % 8);
            b = 8'($urandom);
            if (r < 3) b[7:4] = 4'h2;
            else if (r == 3) b[7:4] = 4'h6;
            else if (r == 4) b[7:4] = 4'hF;
            step(($urandom % 4) != 0, b, ($urandom % 3) != 0);
        end
        for (int i = 0; i < 4; i++) step(0, 8'h00, 1);
        chk(expq.size() == 0, "R10 all issued words delivered", 64'(expq.size()), 64'd0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule